// File: doc/BRIEF.md
# DDR SDRAM power-up command sequencer

This block takes a DDR SDRAM device from power-up to a usable state without any firmware involvement. After a single-cycle start request it waits a stabilization interval, raises the clock-enable line and then emits a fixed series of seven commands onto one phase of a memory-controller command interface: a precharge of all banks, a load of the extended mode register, a mode-register load that also resets the DLL, a second precharge of all banks, two auto-refresh commands and a final mode-register load without DLL reset.

Every command occupies exactly one clock cycle. Between commands the command lines sit in the deselected state for a wait interval that depends on the command just issued; the interval lengths are parameters so that a short simulation can use small values. Busy is raised for the whole run, and a sticky done flag reports completion. Only one run is made per reset: later start requests are ignored. The block drives no data; its data enables and write mask are held inactive.

Top module: `ddr_boot_seq`

## Requirements
- R1: After a synchronous active-high reset, cs_n, ras_n, cas_n and we_n are 1, addr and bank are 0, and cke, busy and done are 0.
- R2: Command lines are active-low; in every cycle with cs_n = 1 the lines ras_n, cas_n and we_n are also 1 and addr and bank are 0.
- R3: Each command is on the bus for one cycle only. The number of deselected cycles between two consecutive commands is GAP_CYCLES after a precharge-all or the extended-mode load, LONG_WAIT after each mode-register load, and SHORT_WAIT after each auto-refresh.
- R4: The commands appear in this order, given as the asserted (low) lines besides cs_n: precharge-all (ras_n, we_n), extended-mode load (ras_n, cas_n, we_n), mode load (ras_n, cas_n, we_n), precharge-all, auto-refresh (ras_n, cas_n), auto-refresh, mode load; no other command ever appears.
- R5: Precharge-all carries addr 0x0400 (bit 10 set) and bank 0; the extended-mode load carries addr 0x0000 and bank 1; the first mode load carries addr 0x0132, the final one 0x0032, and auto-refresh carries addr 0, all with bank 0.
- R6: If start is sampled high at clock edge k while idle, cke becomes 1 after edge k+STAB_CYCLES and stays 1 until reset; the first command is on the bus after edge k+STAB_CYCLES+1.
- R7: busy becomes 1 after the edge that samples start; LONG_WAIT cycles after the final command was on the bus, busy falls and done rises together, and done then stays 1 until reset.
- R8: A start request while busy or after done has no effect: no command is repeated and busy stays as it was.
- R9: wrdata_en, rddata_en and wrdata_mask are 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to run the power-up sequence |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus for the current command |
| bank | output | BANK_W | Bank select for the current command |
| cke | output | 1 | Clock enable to the device |
| wrdata_en | output | 1 | Write data enable, held 0 |
| rddata_en | output | 1 | Read data enable, held 0 |
| wrdata_mask | output | MASK_W | Write data mask, held 0 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, sticky until reset |

## Verification
The assertions watch, on every cycle, the shape of the bus: one-cycle command pulses, quiet lines and zero address whenever chip select is inactive, clock enable high before and during any command, the address and bank tied to each command type, and the mutual exclusion and stickiness of busy and done. What they cannot see is the order of the seven commands and the exact length of each wait; the bench's scoreboard measures the cycle distance between commands, the clock-enable rise and the done rise, and its scenarios show that a start request mid-run or after completion and a reset in the middle of a run behave as required.

// File: rtl/ddr_boot_pkg.sv
package ddr_boot_pkg;

  localparam int unsigned NUM_STEPS = 7;

  typedef enum logic [1:0] {
    WT_GAP,
    WT_SHORT,
    WT_LONG
  } wait_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAB,
    ST_CMD,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  // active-high command bits; the bus drives their inverses
  typedef struct packed {
    logic cs;
    logic ras;
    logic cas;
    logic we;
  } cmd_bits_t;

endpackage

// File: rtl/ddr_boot_rom.sv
module ddr_boot_rom
  import ddr_boot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  output cmd_bits_t         cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_bank,
  output wait_kind_e        wkind
);

  localparam logic [ADDR_W-1:0] A_PREA  = ADDR_W'(11'h400);
  localparam logic [ADDR_W-1:0] A_MRDLL = ADDR_W'(9'h132);
  localparam logic [ADDR_W-1:0] A_MRFIN = ADDR_W'(9'h032);

  always_comb begin
    cmd      = '{cs: 1'b1, ras: 1'b1, cas: 1'b0, we: 1'b1};
    cmd_addr = '0;
    cmd_bank = '0;
    wkind    = WT_GAP;
    case (step)
      STEP_W'(0), STEP_W'(3): begin
        cmd_addr = A_PREA;
        wkind    = WT_GAP;
      end
      STEP_W'(1): begin
        cmd      = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
        cmd_bank = BANK_W'(1);
        wkind    = WT_GAP;
      end
      STEP_W'(2): begin
        cmd      = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
        cmd_addr = A_MRDLL;
        wkind    = WT_LONG;
      end
      STEP_W'(4), STEP_W'(5): begin
        cmd   = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b0};
        wkind = WT_SHORT;
      end
      default: begin
        cmd      = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
        cmd_addr = A_MRFIN;
        wkind    = WT_LONG;
      end
    endcase
  end

endmodule

// File: rtl/ddr_boot_timer.sv
module ddr_boot_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/ddr_boot_phy_reg.sv
module ddr_boot_phy_reg
  import ddr_boot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  cmd_bits_t         cmd,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BANK_W-1:0] bank_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank
);

  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      cs_n  <= 1'b1;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      addr  <= '0;
      bank  <= '0;
    end else begin
      cs_n  <= ~cmd.cs;
      ras_n <= ~cmd.ras;
      cas_n <= ~cmd.cas;
      we_n  <= ~cmd.we;
      addr  <= addr_in;
      bank  <= bank_in;
    end
  end

endmodule

// File: rtl/ddr_boot_seq.sv
module ddr_boot_seq
  import ddr_boot_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int MASK_W      = 4,
  parameter int STAB_CYCLES = 16,
  parameter int GAP_CYCLES  = 2,
  parameter int SHORT_WAIT  = 4,
  parameter int LONG_WAIT   = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              cke,
  output logic              wrdata_en,
  output logic              rddata_en,
  output logic [MASK_W-1:0] wrdata_mask,
  output logic              busy,
  output logic              done
);

  localparam int MAX_A  = (STAB_CYCLES > GAP_CYCLES) ? STAB_CYCLES : GAP_CYCLES;
  localparam int MAX_B  = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int MAX_V  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW     = $clog2(MAX_V + 1);
  localparam int STEP_W = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  cmd_bits_t         rom_cmd;
  logic [ADDR_W-1:0] rom_addr;
  logic [BANK_W-1:0] rom_bank;
  wait_kind_e        rom_wait;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_zero;
  logic              issue;

  ddr_boot_rom #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .STEP_W(STEP_W)) u_rom (
    .step     (step),
    .cmd      (rom_cmd),
    .cmd_addr (rom_addr),
    .cmd_bank (rom_bank),
    .wkind    (rom_wait)
  );

  ddr_boot_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: begin
        tmr_load = start;
        tmr_val  = TW'(STAB_CYCLES - 1);
      end
      ST_CMD: begin
        tmr_load = 1'b1;
        case (rom_wait)
          WT_LONG:  tmr_val = TW'(LONG_WAIT - 1);
          WT_SHORT: tmr_val = TW'(SHORT_WAIT - 1);
          default:  tmr_val = TW'(GAP_CYCLES - 1);
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
      cke   <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_STAB;
          busy  <= 1'b1;
        end
        ST_STAB: if (tmr_zero) begin
          state <= ST_CMD;
          step  <= '0;
          cke   <= 1'b1;
        end
        ST_CMD: state <= ST_WAIT;
        ST_WAIT: if (tmr_zero) begin
          if (step == LAST_STEP) begin
            state <= ST_DONE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            step  <= step + STEP_W'(1);
            state <= ST_CMD;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign issue = (state == ST_CMD);

  ddr_boot_phy_reg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_phy (
    .clk     (clk),
    .rst     (rst),
    .issue   (issue),
    .cmd     (rom_cmd),
    .addr_in (rom_addr),
    .bank_in (rom_bank),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .addr    (addr),
    .bank    (bank)
  );

  assign wrdata_en   = 1'b0;
  assign rddata_en   = 1'b0;
  assign wrdata_mask = '0;

endmodule

// File: rtl/ddr_boot_seq_chk.sv
module ddr_boot_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] bank,
  input logic              cke,
  input logic              busy,
  input logic              done
);

  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (ras_n && cas_n && we_n && addr == '0 && bank == '0));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    !cs_n |=> cs_n);

  p_ras_always_r4: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !ras_n);

  p_prea_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && !we_n) |-> (addr == ADDR_W'(11'h400) && bank == '0));

  p_refresh_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && !cas_n && we_n) |-> (addr == '0 && bank == '0));

  p_bank_emr_r5: assert property (@(posedge clk) disable iff (rst)
    (bank != '0) |-> (!cs_n && !ras_n && !cas_n && !we_n && addr == '0));

  p_cke_first_r6: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> cke);

  p_cke_hold_r6: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !busy);

endmodule

bind ddr_boot_seq ddr_boot_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/ddr_boot_seq_bench.sv
`timescale 1ns/1ps
module ddr_boot_seq_bench;

  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int MASK_W = 4;
  localparam int STAB   = 5;
  localparam int GAP    = 2;
  localparam int SHORTW = 4;
  localparam int LONGW  = 20;

  typedef struct {
    logic       ras;
    logic       cas;
    logic       we;
    int         addr;
    int         bank;
    int         delta;
    string      name;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, wrdata_en, rddata_en, busy, done;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bank;
  logic [MASK_W-1:0] wrdata_mask;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int start_edge = 0;
  int ref_cyc = 0;
  int last_cmd_cyc = 0;
  int cmd_count = 0;
  int r9_bad = 0;
  logic cke_q = 1'b0;
  logic done_q = 1'b0;
  logic finished = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_boot_seq #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MASK_W(MASK_W), .STAB_CYCLES(STAB),
    .GAP_CYCLES(GAP), .SHORT_WAIT(SHORTW), .LONG_WAIT(LONGW)
  ) u_ddr_boot_seq (
    .clk(clk), .rst(rst), .start(start), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .bank(bank), .cke(cke),
    .wrdata_en(wrdata_en), .rddata_en(rddata_en), .wrdata_mask(wrdata_mask),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push(input logic r, input logic c, input logic w, input int a,
                      input int b, input int d, input string n);
    exp_t e;
    e.ras = r; e.cas = c; e.we = w; e.addr = a; e.bank = b; e.delta = d; e.name = n;
    exp_q.push_back(e);
  endtask

  // driver: expected commands with distance (cycles) from the previous event
  task automatic push_sequence();
    push(1, 0, 1, 'h400, 0, STAB + 1,   "R4 prea1");
    push(1, 1, 1, 'h000, 1, GAP + 1,    "R4 emr");
    push(1, 1, 1, 'h132, 0, GAP + 1,    "R4 mr_dll");
    push(1, 0, 1, 'h400, 0, LONGW + 1,  "R4 prea2");
    push(1, 1, 0, 'h000, 0, GAP + 1,    "R4 ref1");
    push(1, 1, 0, 'h000, 0, SHORTW + 1, "R4 ref2");
    push(1, 1, 1, 'h032, 0, SHORTW + 1, "R4 mr_final");
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // monitor: pops and compares commands as they appear
  always @(negedge clk) begin
    if (!rst) begin
      if (wrdata_en || rddata_en || wrdata_mask != '0) r9_bad++;
      if (!cs_n) begin
        cmd_count++;
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected command", cmd_count, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({~ras_n, ~cas_n, ~we_n} == {e.ras, e.cas, e.we}, e.name,
                int'({~ras_n, ~cas_n, ~we_n}), int'({e.ras, e.cas, e.we}));
          check(int'(addr) == e.addr, "R5 address", int'(addr), e.addr);
          check(int'(bank) == e.bank, "R5 bank", int'(bank), e.bank);
          check(cyc - ref_cyc == e.delta, "R3 spacing", cyc - ref_cyc, e.delta);
        end
        ref_cyc = cyc;
        last_cmd_cyc = cyc;
      end
      if (cke && !cke_q)
        check(cyc == start_edge + STAB, "R6 cke rise", cyc, start_edge + STAB);
      if (done && !done_q) begin
        check(cyc == last_cmd_cyc + LONGW, "R7 done rise", cyc, last_cmd_cyc + LONGW);
        check(!busy, "R7 busy low at done", int'(busy), 0);
      end
    end
    cke_q  = cke;
    done_q = done;
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n && ras_n && cas_n && we_n, "R1 lines",
          int'({cs_n, ras_n, cas_n, we_n}), 15);
    check(!cke && !busy && !done, "R1 cke busy done", int'({cke, busy, done}), 0);
    check(addr == '0 && bank == '0, "R1 addr bank", int'(addr), 0);
    rst = 1'b0;
    exp_q.delete();
  endtask

  task automatic run_start();
    pulse_start();
    start_edge = cyc;
    ref_cyc = cyc;
    check(busy, "R7 busy rise", int'(busy), 1);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    check(done, "R7 done reached", int'(done), 1);
    check(exp_q.size() == 0, "R4 all commands seen", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    check(r9_bad == 0, "R9 data enables and mask zero", r9_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    // full run with a start request mid-sequence (R8)
    cmd_count = 0;
    push_sequence();
    run_start();
    repeat (STAB + 6) @(negedge clk);
    pulse_start();
    check(busy, "R8 busy kept on start while busy", int'(busy), 1);
    wait_done();
    check(cmd_count == 7, "R4 command count", cmd_count, 7);
    // start after done is ignored, done sticky
    pulse_start();
    repeat (40) @(negedge clk);
    check(cmd_count == 7, "R8 no commands after done", cmd_count, 7);
    check(done && !busy, "R7 done sticky", int'({done, busy}), 2);
    // reset in the middle of a run
    do_reset();
    cmd_count = 0;
    push_sequence();
    run_start();
    for (int i = 0; i < 500 && cmd_count < 3; i++) @(negedge clk);
    do_reset();
    repeat (10) @(negedge clk);
    check(cmd_count == 3 && !cke, "R1 quiet after mid-run reset", cmd_count, 3);
    // fresh complete run
    cmd_count = 0;
    push_sequence();
    run_start();
    wait_done();
    check(cmd_count == 7, "R4 command count second run", cmd_count, 7);
    finish_run();
  end

endmodule